// File: doc/BRIEF.md
# Key-Unlocked Peripheral Enable Register

This block keeps one enable bit for each of nine on-chip peripherals and drives them out as a vector to the rest of the chip. Software changes these bits through a small register bus. Each transfer has a word address, a write strobe, write data and combinational read data. The enable word cannot be written at will. Software must first write a 32-bit key to a separate lock register. A correct key opens a write window 16 cycles long, and the enable word then accepts exactly one write during that window.

Two states control write access. In state LOCKED the enable word refuses writes. In state OPEN it accepts one. There are five transitions:
- UNLOCK: a correct key moves LOCKED to OPEN.
- RESTART: a correct key in OPEN stays in OPEN and reloads the window count.
- CONSUME: an enable-word write in OPEN returns to LOCKED.
- EXPIRE: the last window cycle passes with no write, and OPEN returns to LOCKED.
- REJECT: any other value written to the lock register forces LOCKED.

A write to the enable word while LOCKED is discarded, and the error output pulses for one cycle.

The reset values of two bits come from a 4-bit boot-select input, which is sampled while reset is held. A host-driven boot can then find its bus interface already enabled.

Top module: `periph_gate_reg`

## Requirements
- R1: While reset is held with boot_sel other than 4'b0111 and 4'b0001, every periph_en bit goes to 0, the enable word reads 0, the lock register reads 0 and wr_err is 0.
- R2: Reset with boot_sel = 4'b0111 sets periph_en[0] (PCI, word bit 20) to 1 and clears all other bits.
- R3: Reset with boot_sel = 4'b0001 sets periph_en[1] (HPI, word bit 18) to 1 and clears all other bits.
- R4: Writing KEY to the lock register (address 0) enters OPEN. From the next cycle, bit 0 of the lock register reads 1.
- R5: In OPEN, the first write to the enable word (address 1) is taken, and the block returns to LOCKED. A second write is dropped.
- R6: The window covers the 16 clock edges after the key write edge. A write on the 16th is accepted, and a write on the 17th is dropped.
- R7: A lock-register write of any value other than KEY does not open the window, and it closes an open one.
- R8: A correct key written in OPEN restarts the 16-cycle count.
- R9: periph_en[i] takes word bit 20-2*i. Index 0..8 is PCI, HPI, serial port 1, serial port 0, I2C, GPIO, timer 0, timer 1, Ethernet MAC. 1 means enabled.
- R10: Word bits 31:21, 19, 17, 15, 13, 11, 9, 7, 5 and 3:0 always read 0, and writing them has no effect.
- R11: An enable-word write while LOCKED leaves periph_en unchanged. It raises wr_err for exactly the cycle after that write edge.
- R12: The enable word reads back its current value at any time, locked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel | input | 4 | Boot mode, sampled during reset for default enables |
| bus_addr | input | ADDR_W | Word address (0 lock, 1 enable word) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| periph_en | output | NUM_PERIPH | Peripheral enables |
| wr_err | output | 1 | One-cycle pulse on a refused enable-word write |

## Verification
A state stuck in OPEN lets a late or second write change periph_en at the edge where it should not. It also leaves the lock status reading 1, and both show at the next sample. A window count that is off by one shows only at the boundary, so writes are placed on exactly the 16th and 17th edge after the key. A wrong boot default or a wrong bit position shows in periph_en straight after reset or after one unlocked write.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    localparam int NUM_PERIPH_DEF = 9;
    localparam int DATA_W         = 32;
    localparam int IDX_PCI        = 0;
    localparam int IDX_HPI        = 1;
    localparam logic [3:0] BOOT_PCI_HOST = 4'b0111;
    localparam logic [3:0] BOOT_HPI_HOST = 4'b0001;

    // Word bit that holds enable index i (PCI at bit 20, stepping down by 2).
    function automatic int en_pos(input int i);
        return 20 - 2 * i;
    endfunction

endpackage

// File: rtl/pgr_unlock_fsm.sv
module pgr_unlock_fsm #(
    parameter int WINDOW_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic key_bad,
    input  logic ena_wr,
    output logic win_open,
    output logic grant,
    output logic err_pulse
);
    import pgr_pkg::*;

    localparam int CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYC - 1);

    lock_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic err_d;

    // Next state and window count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (key_ok) begin
                    state_d = ST_OPEN;      // UNLOCK
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_OPEN: begin
                if (key_ok) begin
                    cnt_d = CNT_LOAD;       // RESTART
                end else if (key_bad) begin
                    state_d = ST_LOCKED;    // REJECT
                end else if (ena_wr) begin
                    state_d = ST_LOCKED;    // CONSUME
                end else if (cnt_q == '0) begin
                    state_d = ST_LOCKED;    // EXPIRE
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        win_open = 1'b0;
        grant    = 1'b0;
        err_d    = 1'b0;
        unique case (state_q)
            ST_LOCKED: err_d = ena_wr;
            ST_OPEN: begin
                win_open = 1'b1;
                grant    = ena_wr;
            end
            default: err_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= err_d;
    end

endmodule

// File: rtl/pgr_enable_bank.sv
module pgr_enable_bank #(
    parameter int NUM_PERIPH = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            boot_sel,
    input  logic                  load,
    input  logic [NUM_PERIPH-1:0] new_bits,
    output logic [NUM_PERIPH-1:0] en_q
);
    import pgr_pkg::*;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
        logic rst_val;
        if (i == IDX_PCI) begin : g_pci
            assign rst_val = (boot_sel == BOOT_PCI_HOST);
        end else if (i == IDX_HPI) begin : g_hpi
            assign rst_val = (boot_sel == BOOT_HPI_HOST);
        end else begin : g_zero
            assign rst_val = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    en_q[i] <= rst_val;
            else if (load) en_q[i] <= new_bits[i];
        end
    end

endmodule

// File: rtl/periph_gate_reg.sv
module periph_gate_reg #(
    parameter int          ADDR_W     = 4,
    parameter int          LOCK_ADDR  = 0,
    parameter int          ENA_ADDR   = 1,
    parameter logic [31:0] KEY        = 32'hC0DE_5A17,
    parameter int          WINDOW_CYC = 16,
    parameter int          NUM_PERIPH = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            boot_sel,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [NUM_PERIPH-1:0] periph_en,
    output logic                  wr_err
);
    import pgr_pkg::*;

    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_ADDR);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_ADDR);

    logic sel_lock, sel_ena, key_ok, key_bad, ena_wr;
    logic win_open, grant;
    logic [NUM_PERIPH-1:0] wr_bits;
    logic [31:0] ena_word;

    assign sel_lock = (bus_addr == A_LOCK);
    assign sel_ena  = (bus_addr == A_ENA);
    assign key_ok   = bus_we && sel_lock && (bus_wdata == KEY);
    assign key_bad  = bus_we && sel_lock && (bus_wdata != KEY);
    assign ena_wr   = bus_we && sel_ena;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_pick
        assign wr_bits[i] = bus_wdata[en_pos(i)];
    end

    pgr_unlock_fsm #(
        .WINDOW_CYC(WINDOW_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_ok   (key_ok),
        .key_bad  (key_bad),
        .ena_wr   (ena_wr),
        .win_open (win_open),
        .grant    (grant),
        .err_pulse(wr_err)
    );

    pgr_enable_bank #(
        .NUM_PERIPH(NUM_PERIPH)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .boot_sel(boot_sel),
        .load    (grant),
        .new_bits(wr_bits),
        .en_q    (periph_en)
    );

    always_comb begin
        ena_word = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            ena_word[en_pos(i)] = periph_en[i];
        end
    end

    always_comb begin
        if (sel_ena)       bus_rdata = ena_word;
        else if (sel_lock) bus_rdata = {31'b0, win_open};
        else               bus_rdata = '0;
    end

endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
    parameter int          ADDR_W     = 4,
    parameter int          LOCK_ADDR  = 0,
    parameter int          ENA_ADDR   = 1,
    parameter logic [31:0] KEY        = 32'hC0DE_5A17,
    parameter int          WINDOW_CYC = 16,
    parameter int          NUM_PERIPH = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [31:0]           bus_wdata,
    input logic [NUM_PERIPH-1:0] periph_en,
    input logic                  wr_err,
    input logic                  win_open
);
    logic is_key, is_bad, is_ena;
    assign is_key = bus_we && (bus_addr == ADDR_W'(LOCK_ADDR)) && (bus_wdata == KEY);
    assign is_bad = bus_we && (bus_addr == ADDR_W'(LOCK_ADDR)) && (bus_wdata != KEY);
    assign is_ena = bus_we && (bus_addr == ADDR_W'(ENA_ADDR));

    // Cycles since the last key write, saturating past the window.
    localparam int SW = $clog2(WINDOW_CYC + 2) + 1;
    logic [SW-1:0] since_key;
    always_ff @(posedge clk) begin
        if (!rst_n)                               since_key <= '0;
        else if (is_key)                          since_key <= SW'(1);
        else if (since_key != '0 &&
                 since_key <= SW'(WINDOW_CYC))    since_key <= since_key + 1'b1;
    end

    a_r4_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        is_key |=> win_open);
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ena && win_open) |=> !win_open);
    a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (since_key >= SW'(1) && since_key <= SW'(WINDOW_CYC)));
    a_r7_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad |=> !win_open);
    a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(is_ena && !win_open));
    a_r11_drop_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_ena && win_open) |=> $stable(periph_en));

endmodule

bind periph_gate_reg pgr_checker #(
    .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .ENA_ADDR(ENA_ADDR),
    .KEY(KEY), .WINDOW_CYC(WINDOW_CYC), .NUM_PERIPH(NUM_PERIPH)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .periph_en(periph_en),
    .wr_err   (wr_err),
    .win_open (win_open)
);

// File: tb/periph_gate_reg_tb_top.sv
`timescale 1ns/1ps
module periph_gate_reg_tb_top;
    localparam logic [31:0] KEY = 32'hC0DE_5A17;
    localparam logic [3:0]  A_LOCK = 4'd0;
    localparam logic [3:0]  A_ENA  = 4'd1;
    localparam int NV = 6;

    localparam logic [31:0] V_DATA [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0010_0000,
                                             32'h0000_0010, 32'hFFEA_AAAF, 32'h0005_0140};
    localparam logic [8:0]  V_EN   [NV] = '{9'h1FF, 9'h000, 9'h001, 9'h100, 9'h000, 9'h0C6};
    localparam logic [31:0] V_RD   [NV] = '{32'h0015_5550, 32'h0, 32'h0010_0000,
                                             32'h0000_0010, 32'h0, 32'h0005_0140};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] boot_sel = 4'd0;
    logic [3:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0] periph_en;
    logic wr_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    periph_gate_reg #(.KEY(KEY)) dut_i (
        .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_en(periph_en), .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] boot);
        rst_n = 1'b0;
        boot_sel = boot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);

        // R1 reset state
        do_reset(4'b0000);
        check("R1 en", 32'(periph_en), 32'h0);
        rd(A_ENA, r);  check("R1 word", r, 32'h0);
        rd(A_LOCK, r); check("R1 lock", r, 32'h0);
        check("R1 err", 32'(wr_err), 32'h0);

        // R9/R10/R5/R12 vector table
        for (int v = 0; v < NV; v++) begin
            wr(A_LOCK, KEY);
            wr(A_ENA, V_DATA[v]);
            check("R9 en", 32'(periph_en), 32'(V_EN[v]));
            rd(A_ENA, r);  check("R10 readback", r, V_RD[v]);
            rd(A_LOCK, r); check("R5 relocked", r, 32'h0);
            idle(1);
            rd(A_ENA, r);  check("R12 locked read", r, V_RD[v]);
        end

        // R11 write without key
        wr(A_ENA, 32'h0015_5550);
        check("R11 err pulse", 32'(wr_err), 32'h1);
        check("R11 en kept", 32'(periph_en), 32'(V_EN[NV-1]));
        idle(1);
        check("R11 err one cycle", 32'(wr_err), 32'h0);

        // R4 key opens, R5 second write dropped
        wr(A_LOCK, KEY);
        rd(A_LOCK, r); check("R4 open", r, 32'h1);
        wr(A_ENA, 32'h0000_0010);
        check("R5 first", 32'(periph_en), 32'h100);
        wr(A_ENA, 32'h0010_0000);
        check("R5 second dropped", 32'(periph_en), 32'h100);
        check("R5 err", 32'(wr_err), 32'h1);

        // R6 last cycle accepted
        wr(A_LOCK, KEY);
        idle(15);
        rd(A_LOCK, r); check("R6 still open", r, 32'h1);
        wr(A_ENA, 32'h0000_1000);
        check("R6 edge 16 taken", 32'(periph_en), 32'h010);
        // R6 one cycle late dropped
        wr(A_LOCK, KEY);
        idle(16);
        rd(A_LOCK, r); check("R6 closed", r, 32'h0);
        wr(A_ENA, 32'h0000_0400);
        check("R6 edge 17 dropped", 32'(periph_en), 32'h010);
        check("R6 err", 32'(wr_err), 32'h1);

        // R7 bad key alone, and closing an open window
        wr(A_LOCK, KEY ^ 32'h1);
        rd(A_LOCK, r); check("R7 no open", r, 32'h0);
        wr(A_LOCK, KEY);
        wr(A_LOCK, 32'h0);
        rd(A_LOCK, r); check("R7 closed", r, 32'h0);
        wr(A_ENA, 32'h0000_0400);
        check("R7 write dropped", 32'(periph_en), 32'h010);

        // R8 restart
        wr(A_LOCK, KEY);
        idle(10);
        wr(A_LOCK, KEY);
        idle(15);
        wr(A_ENA, 32'h0000_0400);
        check("R8 restart", 32'(periph_en), 32'h020);

        // R2 / R3 boot defaults
        do_reset(4'b0111);
        check("R2 pci default", 32'(periph_en), 32'h001);
        rd(A_ENA, r); check("R2 word", r, 32'h0010_0000);
        do_reset(4'b0001);
        check("R3 hpi default", 32'(periph_en), 32'h002);
        rd(A_ENA, r); check("R3 word", r, 32'h0004_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule